// File: doc/BRIEF.md
# Privileged Trap and Interrupt Router

This block decides, every cycle, whether the hart must take a trap. It looks at pending interrupts, a synchronous exception offered by the pipeline, the two delegation masks and its own privilege and status state. From these it picks one winner and chooses where execution resumes: the machine vector, the supervisor vector, the debug ROM, or the debug-exception address. The choice is combinational and appears on `trap_valid`, `dbg_enter` and `next_pc`.

A one-cycle `commit` strobe makes the outcome permanent in a single clock edge. It updates the privilege level, the interrupt-enable stack, the cause, exception PC and faulting-address registers of the target mode, or the debug record. A separate `set_en` port loads privilege and the two IE bits. It stands in for return instructions and status writes made elsewhere in the core. `dbg_clr` leaves debug mode.

Top module: `trap_router`

## Requirements
- R1: An interrupt whose bit is clear in `irq_deleg` is enabled when privilege is below machine (encoding U=0, S=1, H=2, M=3), or when privilege is machine and `st_mie` is 1.
- R2: An interrupt whose bit is set in `irq_deleg` is enabled only when privilege is user, or when privilege is supervisor and `st_sie` is 1. In machine mode it is never taken.
- R3: Among enabled interrupts the lowest bit index wins. The recorded cause is that index with bit XLEN-1 set.
- R4: A trap goes to supervisor (PC from `svec_base`, cause and PC into `scause`/`sepc`) only when privilege is U or S, the cause number is below XLEN, and its bit is set in the mask for its kind (`irq_deleg` for interrupts, `exc_deleg` for exceptions). Otherwise it goes to machine (`mvec_base`, `mcause`/`mepc`).
- R5: On a trap into a mode, that mode's previous-IE bit takes the IE bit of the old privilege (0 for user). Its previous-privilege field takes the old privilege. Its IE bit is cleared. The other mode's IE bit is kept.
- R6: An exception with code 3 (breakpoint) enters debug when `brk_dbg_en[priv]` is 1. `next_pc` is the debug ROM address. On commit, `dbg_cause` becomes 1, `dbg_prv` takes the old privilege, `dpc` takes `exc_pc` and privilege becomes machine. The cause and EPC registers are untouched.
- R7: While `dbg_cause` is non-zero, any other trap only sets `next_pc` to the debug-exception address. Commit changes no privilege, status, cause or EPC state.
- R8: The target mode's bad-address register is written only when `bad_valid` is 1 at commit.
- R9: A `set_en` request for privilege 2 (reserved) loads user (0).
- R10: When an enabled interrupt and an exception are both present, the interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; privilege resets to machine, all else to 0 |
| irq_pend | input | XLEN | Pending interrupt bits |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| mvec_base | input | XLEN | Machine trap vector |
| svec_base | input | XLEN | Supervisor trap vector |
| exc_valid | input | 1 | Synchronous exception offered |
| exc_code | input | XLEN | Exception cause number |
| exc_pc | input | XLEN | PC of the trapping instruction |
| bad_valid | input | 1 | Trap carries a faulting address |
| bad_addr | input | XLEN | Faulting address |
| brk_dbg_en | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| commit | input | 1 | Commit the current trap decision |
| set_en | input | 1 | Load privilege and IE bits (ignored during commit) |
| set_priv | input | 2 | Privilege to load |
| set_mie | input | 1 | Machine IE to load |
| set_sie | input | 1 | Supervisor IE to load |
| dbg_clr | input | 1 | Clear the debug record (ignored during commit) |
| trap_valid | output | 1 | A trap would be taken now |
| dbg_enter | output | 1 | The trap is a debug entry |
| next_pc | output | XLEN | Resume address for the trap |
| priv | output | 2 | Current privilege |
| st_mie | output | 1 | Machine interrupt enable |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_mpie | output | 1 | Machine previous IE |
| st_spie | output | 1 | Supervisor previous IE |
| st_mpp | output | 2 | Machine previous privilege |
| st_spp | output | 1 | Supervisor previous privilege |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mbad | output | XLEN | Machine faulting address |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| sbad | output | XLEN | Supervisor faulting address |
| dbg_cause | output | 3 | Debug cause record (0 = not in debug) |
| dbg_prv | output | 2 | Privilege at debug entry |
| dpc | output | XLEN | Debug PC |

## Verification
The hardest state to reach is a trap taken while a debug cause is already recorded. Only a breakpoint whose privilege has its debug enable set can create that record, and the first entry forces machine mode. The stimulus first commits a breakpoint from supervisor mode with the enable set for that level. It then offers a second, ordinary exception, and checks that only the resume address moves while the cause, EPC and privilege stay frozen. The lowest-index rule under mixed delegation needs user mode with several pending bits, some delegated and some not. The table walk sets that up directly.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;
    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_H = 2'd2;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam logic [2:0] DBG_WHY_SWBP = 3'd1;

    typedef struct packed {
        logic       mie;
        logic       sie;
        logic       mpie;
        logic       spie;
        logic [1:0] mpp;
        logic       spp;
    } stat_t;
endpackage

// File: rtl/irq_select.sv
module irq_select
    import trap_router_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int IW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] pend,
    input  logic [XLEN-1:0] deleg,
    input  logic [1:0]      prv,
    input  logic            mie,
    input  logic            sie,
    output logic            any,
    output logic [IW-1:0]   idx
);
    logic            m_ok;
    logic            s_ok;
    logic [XLEN-1:0] live;

    always_comb begin
        m_ok = (prv != PRV_M) || mie;
        s_ok = (prv == PRV_U) || ((prv == PRV_S) && sie);
        live = pend & ((~deleg & {XLEN{m_ok}}) | (deleg & {XLEN{s_ok}}));
        any  = |live;
        idx  = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (live[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_router_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int IW = $clog2(XLEN)
) (
    input  logic            is_irq,
    input  logic [IW-1:0]   irq_idx,
    input  logic [XLEN-1:0] exc_code,
    input  logic [XLEN-1:0] irq_deleg,
    input  logic [XLEN-1:0] exc_deleg,
    input  logic [1:0]      prv,
    output logic            to_s,
    output logic [XLEN-1:0] cause
);
    localparam logic [XLEN-1:0] XL = XLEN;

    logic [XLEN-1:0] num;
    logic [XLEN-1:0] mask;

    always_comb begin
        num   = is_irq ? {{(XLEN-IW){1'b0}}, irq_idx} : exc_code;
        mask  = is_irq ? irq_deleg : exc_deleg;
        to_s  = ((prv == PRV_U) || (prv == PRV_S)) && (num < XL) && mask[num[IW-1:0]];
        cause = is_irq ? {1'b1, {(XLEN-1-IW){1'b0}}, irq_idx} : exc_code;
    end
endmodule

// File: rtl/trap_router.sv
module trap_router
    import trap_router_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] DBG_ROM  = 32'h0000_0800,
    parameter logic [31:0] DBG_EXC  = 32'h0000_0808,
    parameter int          BRK_CODE = 3,
    localparam int IW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] irq_pend,
    input  logic [XLEN-1:0] irq_deleg,
    input  logic [XLEN-1:0] exc_deleg,
    input  logic [XLEN-1:0] mvec_base,
    input  logic [XLEN-1:0] svec_base,
    input  logic            exc_valid,
    input  logic [XLEN-1:0] exc_code,
    input  logic [XLEN-1:0] exc_pc,
    input  logic            bad_valid,
    input  logic [XLEN-1:0] bad_addr,
    input  logic [3:0]      brk_dbg_en,
    input  logic            commit,
    input  logic            set_en,
    input  logic [1:0]      set_priv,
    input  logic            set_mie,
    input  logic            set_sie,
    input  logic            dbg_clr,
    output logic            trap_valid,
    output logic            dbg_enter,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      priv,
    output logic            st_mie,
    output logic            st_sie,
    output logic            st_mpie,
    output logic            st_spie,
    output logic [1:0]      st_mpp,
    output logic            st_spp,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] mbad,
    output logic [XLEN-1:0] scause,
    output logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] sbad,
    output logic [2:0]      dbg_cause,
    output logic [1:0]      dbg_prv,
    output logic [XLEN-1:0] dpc
);
    localparam logic [XLEN-1:0] BRK = XLEN'(BRK_CODE);

    typedef struct packed {
        logic [1:0]      prv;
        stat_t           st;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mbad;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] sbad;
        logic [2:0]      dwhy;
        logic [1:0]      dprv;
        logic [XLEN-1:0] dpc;
    } state_t;

    state_t state_d, state_q;

    logic            irq_any;
    logic [IW-1:0]   irq_idx;
    logic            to_s;
    logic [XLEN-1:0] cause_w;
    logic            brk_hit;
    logic            dbg_act;
    logic            old_ie;

    irq_select #(.XLEN(XLEN)) u_sel (
        .pend  (irq_pend),
        .deleg (irq_deleg),
        .prv   (state_q.prv),
        .mie   (state_q.st.mie),
        .sie   (state_q.st.sie),
        .any   (irq_any),
        .idx   (irq_idx)
    );

    trap_route #(.XLEN(XLEN)) u_route (
        .is_irq    (irq_any),
        .irq_idx   (irq_idx),
        .exc_code  (exc_code),
        .irq_deleg (irq_deleg),
        .exc_deleg (exc_deleg),
        .prv       (state_q.prv),
        .to_s      (to_s),
        .cause     (cause_w)
    );

    always_comb begin
        trap_valid = irq_any || exc_valid;
        brk_hit    = !irq_any && exc_valid && (exc_code == BRK) && brk_dbg_en[state_q.prv];
        dbg_act    = (state_q.dwhy != 3'd0);
        dbg_enter  = brk_hit;
        old_ie     = (state_q.prv == PRV_M) ? state_q.st.mie :
                     (state_q.prv == PRV_S) ? state_q.st.sie : 1'b0;
        if (brk_hit)      next_pc = XLEN'(DBG_ROM);
        else if (dbg_act) next_pc = XLEN'(DBG_EXC);
        else if (to_s)    next_pc = svec_base;
        else              next_pc = mvec_base;

        state_d = state_q;
        if (commit && trap_valid) begin
            if (brk_hit) begin
                state_d.dwhy = DBG_WHY_SWBP;
                state_d.dprv = state_q.prv;
                state_d.dpc  = exc_pc;
                state_d.prv  = PRV_M;
            end else if (!dbg_act) begin
                if (to_s) begin
                    state_d.scause  = cause_w;
                    state_d.sepc    = exc_pc;
                    if (bad_valid) state_d.sbad = bad_addr;
                    state_d.st.spie = old_ie;
                    state_d.st.spp  = state_q.prv[0];
                    state_d.st.sie  = 1'b0;
                    state_d.prv     = PRV_S;
                end else begin
                    state_d.mcause  = cause_w;
                    state_d.mepc    = exc_pc;
                    if (bad_valid) state_d.mbad = bad_addr;
                    state_d.st.mpie = old_ie;
                    state_d.st.mpp  = state_q.prv;
                    state_d.st.mie  = 1'b0;
                    state_d.prv     = PRV_M;
                end
            end
        end else if (!commit) begin
            if (set_en) begin
                state_d.prv    = (set_priv == PRV_H) ? PRV_U : set_priv;
                state_d.st.mie = set_mie;
                state_d.st.sie = set_sie;
            end
            if (dbg_clr) state_d.dwhy = 3'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.prv <= PRV_M;
        end else begin
            state_q <= state_d;
        end
    end

    assign priv      = state_q.prv;
    assign st_mie    = state_q.st.mie;
    assign st_sie    = state_q.st.sie;
    assign st_mpie   = state_q.st.mpie;
    assign st_spie   = state_q.st.spie;
    assign st_mpp    = state_q.st.mpp;
    assign st_spp    = state_q.st.spp;
    assign mcause    = state_q.mcause;
    assign mepc      = state_q.mepc;
    assign mbad      = state_q.mbad;
    assign scause    = state_q.scause;
    assign sepc      = state_q.sepc;
    assign sbad      = state_q.sbad;
    assign dbg_cause = state_q.dwhy;
    assign dbg_prv   = state_q.dprv;
    assign dpc       = state_q.dpc;

    assert_m_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRV_M && !st_mie && !exc_valid) |-> !trap_valid);

    assert_s_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRV_S && !st_sie && ((irq_pend & ~irq_deleg) == '0) && !exc_valid) |-> !trap_valid);

    assert_m_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trap_valid && !dbg_enter && !dbg_act && priv == PRV_M) |=> (priv == PRV_M));

    assert_ie_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trap_valid && !dbg_enter && !dbg_act) |=>
        ((priv == PRV_M && !st_mie) || (priv == PRV_S && !st_sie)));

    assert_dbg_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dbg_enter) |=> (priv == PRV_M && dbg_cause != 3'd0));

    assert_dbg_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trap_valid && !dbg_enter && dbg_cause != 3'd0) |=>
        ($stable(priv) && $stable(mcause) && $stable(scause) && $stable(mepc) && $stable(sepc)));

    assert_bad_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !bad_valid) |=> ($stable(mbad) && $stable(sbad)));

    assert_h_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !commit && set_priv == PRV_H) |=> (priv == PRV_U));
endmodule

// File: tb/trap_router_tb.sv
`timescale 1ns/1ps
module trap_router_tb;
    localparam logic [31:0] MVEC = 32'h0000_0100;
    localparam logic [31:0] SVEC = 32'h0000_0200;
    localparam logic [31:0] DROM = 32'h0000_0800;
    localparam logic [31:0] DEXC = 32'h0000_0808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_pend = '0, irq_deleg = '0, exc_deleg = '0;
    logic        exc_valid = 1'b0;
    logic [31:0] exc_code = '0, exc_pc = '0, bad_addr = '0;
    logic        bad_valid = 1'b0;
    logic [3:0]  brk_dbg_en = '0;
    logic        commit = 1'b0, set_en = 1'b0, set_mie = 1'b0, set_sie = 1'b0, dbg_clr = 1'b0;
    logic [1:0]  set_priv = '0;

    logic        trap_valid, dbg_enter;
    logic [31:0] next_pc;
    logic [1:0]  priv, st_mpp, dbg_prv;
    logic        st_mie, st_sie, st_mpie, st_spie, st_spp;
    logic [31:0] mcause, mepc, mbad, scause, sepc, sbad, dpc;
    logic [2:0]  dbg_cause;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    trap_router u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_deleg(irq_deleg),
        .exc_deleg(exc_deleg), .mvec_base(MVEC), .svec_base(SVEC),
        .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc),
        .bad_valid(bad_valid), .bad_addr(bad_addr), .brk_dbg_en(brk_dbg_en),
        .commit(commit), .set_en(set_en), .set_priv(set_priv), .set_mie(set_mie),
        .set_sie(set_sie), .dbg_clr(dbg_clr), .trap_valid(trap_valid),
        .dbg_enter(dbg_enter), .next_pc(next_pc), .priv(priv), .st_mie(st_mie),
        .st_sie(st_sie), .st_mpie(st_mpie), .st_spie(st_spie), .st_mpp(st_mpp),
        .st_spp(st_spp), .mcause(mcause), .mepc(mepc), .mbad(mbad),
        .scause(scause), .sepc(sepc), .sbad(sbad), .dbg_cause(dbg_cause),
        .dbg_prv(dbg_prv), .dpc(dpc)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  prv;
        logic        mie;
        logic        sie;
        logic [15:0] pend;
        logic [15:0] idel;
        logic        exv;
        logic [4:0]  code;
        logic [15:0] edel;
        logic        xtrap;
        logic        xs;
        logic [31:0] xcause;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{4'd1, 2'd3, 1'b1, 1'b0, 16'h0080, 16'h0000, 1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 32'h8000_0007}, // R1 M with mie
        '{4'd1, 2'd3, 1'b0, 1'b0, 16'h0080, 16'h0000, 1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 32'h0},          // R1 M masked
        '{4'd1, 2'd0, 1'b0, 1'b0, 16'h0080, 16'h0000, 1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 32'h8000_0007}, // R1 below M
        '{4'd2, 2'd1, 1'b0, 1'b1, 16'h0002, 16'h0002, 1'b0, 5'd0,  16'h0000, 1'b1, 1'b1, 32'h8000_0001}, // R2 S with sie
        '{4'd2, 2'd1, 1'b0, 1'b0, 16'h0002, 16'h0002, 1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 32'h0},          // R2 S masked
        '{4'd2, 2'd3, 1'b1, 1'b0, 16'h0002, 16'h0002, 1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 32'h0},          // R2 delegated in M
        '{4'd3, 2'd0, 1'b0, 1'b0, 16'h00A2, 16'h0022, 1'b0, 5'd0,  16'h0000, 1'b1, 1'b1, 32'h8000_0001}, // R3 lowest wins
        '{4'd3, 2'd1, 1'b0, 1'b0, 16'h00A0, 16'h0020, 1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 32'h8000_0007}, // R3 masked lower skipped
        '{4'd4, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 5'd13, 16'h2000, 1'b1, 1'b1, 32'd13},        // R4 exc to S
        '{4'd4, 2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 5'd13, 16'h2000, 1'b1, 1'b0, 32'd13},        // R4 M never delegates
        '{4'd4, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 5'd8,  16'h0000, 1'b1, 1'b0, 32'd8}          // R4 not delegated
    };

    task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic set_state(input logic [1:0] p, input logic m, input logic s);
        @(negedge clk);
        set_en = 1'b1; set_priv = p; set_mie = m; set_sie = s;
        @(negedge clk);
        set_en = 1'b0;
    endtask

    task automatic offer(input logic [31:0] pend, input logic exv, input logic [31:0] code,
                         input logic [31:0] pc, input logic bv, input logic [31:0] ba);
        irq_pend = pend; exc_valid = exv; exc_code = code; exc_pc = pc;
        bad_valid = bv; bad_addr = ba;
        #1;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        irq_pend = '0; exc_valid = 1'b0; bad_valid = 1'b0;
        #1;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        chk(4, {30'd0, priv}, 32'd3, "reset privilege is machine");
        chk(6, {29'd0, dbg_cause}, 32'd0, "reset debug cause");
        chk(4, mcause, 32'd0, "reset mcause");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            set_state(TBL[i].prv, TBL[i].mie, TBL[i].sie);
            irq_deleg = {16'h0, TBL[i].idel};
            exc_deleg = {16'h0, TBL[i].edel};
            offer({16'h0, TBL[i].pend}, TBL[i].exv, {27'd0, TBL[i].code}, 32'h1000 + 32'(i * 4), 1'b0, '0);
            chk(int'(TBL[i].rq), {31'd0, trap_valid}, {31'd0, TBL[i].xtrap}, "trap decision");
            if (TBL[i].xtrap)
                chk(int'(TBL[i].rq), next_pc, TBL[i].xs ? SVEC : MVEC, "vector");
            do_commit();
            if (TBL[i].xtrap) begin
                chk(int'(TBL[i].rq), {30'd0, priv}, TBL[i].xs ? 32'd1 : 32'd3, "target privilege");
                chk(int'(TBL[i].rq), TBL[i].xs ? scause : mcause, TBL[i].xcause, "cause");
                chk(int'(TBL[i].rq), TBL[i].xs ? sepc : mepc, 32'h1000 + 32'(i * 4), "epc");
            end else begin
                chk(int'(TBL[i].rq), {30'd0, priv}, {30'd0, TBL[i].prv}, "privilege kept");
            end
        end
        irq_deleg = '0; exc_deleg = '0;

        // R5: S -> M, stack records S and its IE
        set_state(2'd1, 1'b0, 1'b1);
        offer('0, 1'b1, 32'd2, 32'h2000, 1'b0, '0);
        do_commit();
        chk(5, {30'd0, st_mpp}, 32'd1, "mpp takes old S");
        chk(5, {31'd0, st_mpie}, 32'd1, "mpie takes sie");
        chk(5, {31'd0, st_mie}, 32'd0, "mie cleared");

        // R5: U -> S, user IE reads as 0, mie untouched
        set_state(2'd0, 1'b1, 1'b1);
        exc_deleg = 32'h0000_0004;
        offer('0, 1'b1, 32'd2, 32'h2004, 1'b0, '0);
        do_commit();
        exc_deleg = '0;
        chk(5, {30'd0, priv}, 32'd1, "in S");
        chk(5, {31'd0, st_spp}, 32'd0, "spp takes U");
        chk(5, {31'd0, st_spie}, 32'd0, "spie from user");
        chk(5, {31'd0, st_sie}, 32'd0, "sie cleared");
        chk(5, {31'd0, st_mie}, 32'd1, "mie kept");

        // R8: faulting address only when flagged
        set_state(2'd3, 1'b0, 1'b0);
        offer('0, 1'b1, 32'd5, 32'h2100, 1'b1, 32'hDEAD_0000);
        do_commit();
        chk(8, mbad, 32'hDEAD_0000, "bad address written");
        offer('0, 1'b1, 32'd7, 32'h2104, 1'b0, 32'h1234_5678);
        do_commit();
        chk(8, mbad, 32'hDEAD_0000, "bad address kept");
        chk(8, mcause, 32'd7, "cause of second trap");

        // R10: interrupt beats exception
        set_state(2'd3, 1'b1, 1'b0);
        offer(32'h0000_0008, 1'b1, 32'd5, 32'h2200, 1'b0, '0);
        do_commit();
        chk(10, mcause, 32'h8000_0003, "interrupt wins");

        // R9: reserved level maps to user
        set_state(2'd2, 1'b0, 1'b0);
        chk(9, {30'd0, priv}, 32'd0, "H request lands in U");

        // R6: breakpoint with enable clear for user traps normally
        brk_dbg_en = 4'b0010;
        set_state(2'd0, 1'b0, 1'b0);
        offer('0, 1'b1, 32'd3, 32'h3000, 1'b0, '0);
        chk(6, {31'd0, dbg_enter}, 32'd0, "no debug entry when disabled");
        chk(6, next_pc, MVEC, "normal vector");
        do_commit();
        chk(6, mcause, 32'd3, "breakpoint recorded as trap");
        chk(6, {29'd0, dbg_cause}, 32'd0, "debug cause stays clear");

        // R6: breakpoint from S with enable set
        set_state(2'd1, 1'b0, 1'b0);
        offer('0, 1'b1, 32'd3, 32'h4444, 1'b0, '0);
        chk(6, {31'd0, dbg_enter}, 32'd1, "debug entry flagged");
        chk(6, next_pc, DROM, "debug rom address");
        do_commit();
        chk(6, {30'd0, priv}, 32'd3, "machine after entry");
        chk(6, {29'd0, dbg_cause}, 32'd1, "debug cause code");
        chk(6, {30'd0, dbg_prv}, 32'd1, "debug old privilege");
        chk(6, dpc, 32'h4444, "debug pc");
        chk(6, mcause, 32'd3, "mcause untouched by entry");
        keep = mepc;

        // R7: nested trap in debug only redirects
        offer('0, 1'b1, 32'd5, 32'h5555, 1'b0, '0);
        chk(7, next_pc, DEXC, "debug exception address");
        do_commit();
        chk(7, mcause, 32'd3, "mcause frozen");
        chk(7, mepc, keep, "mepc frozen");
        chk(7, {30'd0, priv}, 32'd3, "privilege frozen");

        @(negedge clk); dbg_clr = 1'b1;
        @(negedge clk); dbg_clr = 1'b0;
        #1;
        chk(7, {29'd0, dbg_cause}, 32'd0, "debug record cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule